// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital controller of a six-bit step attenuator with 0.5 dB resolution. It turns a set of slow external control pins into the six-bit word that sets the switch array. There are two ways to program it. In serial mode, a data/clock pair loads a shift register, and a latch-enable pin gates that register onto the output. In parallel mode, six level pins set the word. The same latch-enable pin then chooses between a direct mode, where the output tracks the pins, and a latched mode, where it holds the value last captured.

All pins are asynchronous to the chip, so each one passes through a two-stage synchronizer clocked by a fast system clock. The serial clock is recognised by a rising-edge detector that works on the synchronized copy. While the power-on reset is asserted, the block computes a power-up word from the synchronized pins and holds it. In serial mode that word is the parallel pins. In parallel mode with latch-enable low, it is a preset picked by two select pins. In parallel mode with latch-enable high, it is the parallel pins. The power-up word is also preloaded into the shift register, so the output keeps it until new data is shifted in or captured.

Every input is a plain level pin sampled on every clock, and there is no valid/ready handshake. The output word always carries the current setting. There is no back-pressure: a pin change that is faster than the synchronizers can follow is simply not seen.

Top module: `stepatt_ctrl`

## Requirements
- R1: `mode_ser_i` high selects serial control and low selects parallel control. In parallel mode, serial clock activity has no effect on the output.
- R2: `att_word_o` bit 5 weighs 16 dB, bit 4 weighs 8 dB, bit 3 weighs 4 dB, bit 2 weighs 2 dB, bit 1 weighs 1 dB and bit 0 weighs 0.5 dB. The first serial bit shifted in ends up in bit 5, and the sixth ends up in bit 0.
- R3: The shift register takes `ser_dat_i` on every rising edge of `ser_clk_i`, whatever the level of `lat_en_i`. While latch-enable is low, shifting does not change the output.
- R4: In serial mode with latch-enable high, the output follows the shift register, including a shift detected in the same cycle. Once latch-enable is seen low, the output holds. A shift detected in the first low cycle is not captured.
- R5: In parallel mode with latch-enable high, the output follows `par_word_i`.
- R6: In parallel mode with latch-enable low, the output keeps the value it had when latch-enable was last seen high. Parallel pin changes are ignored until the next latch-enable pulse.
- R7: During reset in serial mode, the output equals `par_word_i`.
- R8: During reset in parallel mode with latch-enable low, the output is a preset set by `preset_sel_i`: 00 gives 000000, 01 gives 010000 (8 dB), 10 gives 100000 (16 dB) and 11 gives 111110 (31 dB).
- R9: During reset in parallel mode with latch-enable high, `preset_sel_i` is ignored and the output equals `par_word_i`.
- R10: A pin value first sampled at clock edge k affects the output at edge k+2. Serial clock edges are found from the synchronized copy.
- R11: After reset is released, the output keeps the power-up word until latch-enable is high (a parallel capture) or a serial shift is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Power-on reset, active low, sampled synchronously |
| mode_ser_i | input | 1 | 1 = serial control, 0 = parallel control |
| par_word_i | input | 6 | Parallel attenuation pins, also the power-up source |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_clk_i | input | 1 | Serial clock, shifts on the rising edge |
| lat_en_i | input | 1 | Latch gate (serial) or direct/latched select (parallel) |
| preset_sel_i | input | 2 | Preset select used at power-up in latched parallel mode |
| att_word_o | output | 6 | Attenuation word to the switch array |

## Verification
The subtle collision is a serial shift and the closing of the latch landing on the same system clock. The bench provokes it in two ways. First, it drives the serial clock high and latch-enable low at the same instant, so that both synchronized edges appear together and the new bit must stay out of the output. Second, it drives the serial clock one cycle earlier, so the shift is seen while the latch is still open and must reach the output. In both cases, a following latch pulse or the held value shows what the shift register really holds. A behavioural reference model with a two-sample pin history is compared against the output on every clock.

// File: rtl/stepatt_pkg.sv
package stepatt_pkg;
  localparam int ATT_W = 6;
  typedef logic [ATT_W-1:0] att_t;

  // Preset words used at power-up in latched parallel mode.
  // sel[1] adds the 16 dB bit, sel[0] adds the 8 dB bit, and both together give 31 dB.
  function automatic att_t preset_word(input logic [1:0] sel);
    case (sel)
      2'b01:   return att_t'(6'b010000);
      2'b10:   return att_t'(6'b100000);
      2'b11:   return att_t'(6'b111110);
      default: return '0;
    endcase
  endfunction

  function automatic att_t powerup_word(input logic ser, input logic le,
                                        input att_t par, input logic [1:0] sel);
    if (ser || le) return par;
    return preset_word(sel);
  endfunction
endpackage

// File: rtl/stepatt_sync.sv
module stepatt_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  // No reset: the chain keeps tracking the pins while reset is held.
  always_ff @(posedge clk) stg[0] <= d_i;

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/stepatt_edge.sv
module stepatt_edge (
  input  logic clk,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/stepatt_shreg.sv
module stepatt_shreg
  import stepatt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  att_t load_i,
  input  logic shift_i,
  input  logic bit_i,
  output att_t q_o,
  output att_t nxt_o
);
  att_t q;

  // The newest bit enters at the LSB, so the first bit in reaches the MSB after six shifts.
  assign nxt_o = shift_i ? {q[ATT_W-2:0], bit_i} : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= load_i;
    else        q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/stepatt_ctrl.sv
module stepatt_ctrl
  import stepatt_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ser_i,
  input  logic [ATT_W-1:0] par_word_i,
  input  logic             ser_dat_i,
  input  logic             ser_clk_i,
  input  logic             lat_en_i,
  input  logic [1:0]       preset_sel_i,
  output logic [ATT_W-1:0] att_word_o
);
  localparam int SYNC_W = 4 + ATT_W + 2;

  logic [SYNC_W-1:0] pins_raw, pins_s;
  logic       mode_s, le_s, sck_s, dat_s;
  att_t       par_s;
  logic [1:0] sel_s;
  logic       ser_rise;
  att_t       pu_word, sr_q, sr_nxt, att_q;

  assign pins_raw = {mode_ser_i, lat_en_i, ser_clk_i, ser_dat_i, par_word_i, preset_sel_i};

  stepatt_sync #(.W(SYNC_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .d_i (pins_raw),
    .q_o (pins_s)
  );

  assign {mode_s, le_s, sck_s, dat_s, par_s, sel_s} = pins_s;

  stepatt_edge u_sck_edge (
    .clk    (clk),
    .lvl_i  (sck_s),
    .rise_o (ser_rise)
  );

  assign pu_word = powerup_word(mode_s, le_s, par_s, sel_s);

  stepatt_shreg u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (pu_word),
    .shift_i (ser_rise),
    .bit_i   (dat_s),
    .q_o     (sr_q),
    .nxt_o   (sr_nxt)
  );

  // The latch is open while latch-enable is high: in serial mode it passes the
  // shift register's next value, in parallel mode it passes the pins.
  always_ff @(posedge clk) begin
    if (!rst_n)    att_q <= pu_word;
    else if (le_s) att_q <= mode_s ? sr_nxt : par_s;
  end

  assign att_word_o = att_q;
endmodule

// File: rtl/stepatt_ctrl_chk.sv
module stepatt_ctrl_chk
  import stepatt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic le_s,
  input logic mode_s,
  input logic ser_rise,
  input logic dat_s,
  input att_t par_s,
  input att_t sr_q,
  input att_t att_word_o
);
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !le_s |=> $stable(att_word_o)); // R4

  AST_SERIAL_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && mode_s) |=> (att_word_o == sr_q)); // R4

  AST_PARALLEL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && !mode_s) |=> (att_word_o == $past(par_s))); // R5

  AST_NO_SHIFT_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_rise |=> $stable(sr_q)); // R3

  AST_NEWEST_BIT_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rise |=> (sr_q[0] == $past(dat_s))); // R2
endmodule

bind stepatt_ctrl stepatt_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .le_s       (le_s),
  .mode_s     (mode_s),
  .ser_rise   (ser_rise),
  .dat_s      (dat_s),
  .par_s      (par_s),
  .sr_q       (sr_q),
  .att_word_o (att_word_o)
);

// File: tb/stepatt_ctrl_tb.sv
module stepatt_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, le = 1'b0, sck = 1'b0, sdat = 1'b0;
  logic [5:0] par = 6'h00;
  logic [1:0] sel = 2'b00;
  logic [5:0] att;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  stepatt_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_ser_i   (mode),
    .par_word_i   (par),
    .ser_dat_i    (sdat),
    .ser_clk_i    (sck),
    .lat_en_i     (le),
    .preset_sel_i (sel),
    .att_word_o   (att)
  );

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: pins seen two samples late, serial edges from the sample history.
  typedef struct packed {
    logic mode; logic le; logic sck; logic sdat; logic [5:0] par; logic [1:0] sel;
  } pin_t;
  pin_t hist[$];
  int   m_sr = 0, m_att = 0;
  bit   m_valid = 1'b0;

  function automatic int preset_of(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 16;
      2'b10: return 32;
      default: return 62;
    endcase
  endfunction

  always @(posedge clk) begin
    pin_t cur, p2, p3;
    cur = '{mode, le, sck, sdat, par, sel};
    if (hist.size() >= 3) begin
      p2 = hist[hist.size()-2];
      p3 = hist[hist.size()-3];
      if (!rst_n) begin
        m_sr    = (p2.mode || p2.le) ? int'(p2.par) : preset_of(p2.sel);
        m_att   = m_sr;
        m_valid = 1'b1;
      end else if (m_valid) begin
        if (p2.sck && !p3.sck) m_sr = ((m_sr * 2) + int'(p2.sdat)) % 64;
        if (p2.le) m_att = p2.mode ? m_sr : int'(p2.par);
      end
      void'(hist.pop_front());
    end
    hist.push_back(cur);
  end

  always @(negedge clk) if (m_valid) chk(cur_req, att, m_att[5:0]);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic m, input logic l, input logic [5:0] p, input logic [1:0] s);
    @(negedge clk);
    mode = m; le = l; par = p; sel = s; sck = 1'b0; rst_n = 1'b0;
    tick(6);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic shift_bit(input logic b);
    sdat = b; tick(3);
    sck = 1'b1; tick(3);
    sck = 1'b0; tick(3);
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic le_pulse();
    le = 1'b1; tick(4);
    le = 1'b0; tick(4);
  endtask

  initial begin
    // Power-up selection
    cur_req = "R7";  do_reset(1'b1, 1'b0, 6'h2A, 2'b11); chk("R7 serial power-up", att, 6'h2A);
    cur_req = "R8";  do_reset(1'b0, 1'b0, 6'h15, 2'b00); chk("R8 preset 00", att, 6'b000000);
    do_reset(1'b0, 1'b0, 6'h15, 2'b01); chk("R8 preset 01", att, 6'b010000);
    do_reset(1'b0, 1'b0, 6'h15, 2'b10); chk("R8 preset 10", att, 6'b100000);
    do_reset(1'b0, 1'b0, 6'h15, 2'b11); chk("R8 preset 11", att, 6'b111110);
    cur_req = "R9";  do_reset(1'b0, 1'b1, 6'h05, 2'b11); chk("R9 direct power-up", att, 6'h05);

    // Power-up value persists until a capture
    cur_req = "R11"; do_reset(1'b0, 1'b0, 6'h00, 2'b10);
    par = 6'h3F; tick(6); chk("R11 preset kept", att, 6'b100000);

    // Parallel direct with latency
    cur_req = "R10"; le = 1'b1; tick(6);
    par = 6'h15; tick(2); chk("R10 not yet", att, 6'h3F);
    tick(1); chk("R10 after two edges", att, 6'h15);
    cur_req = "R5"; par = 6'h2C; tick(4); chk("R5 direct follow", att, 6'h2C);

    // Parallel latched
    cur_req = "R6"; le = 1'b0; tick(4); par = 6'h33; tick(5); chk("R6 hold while low", att, 6'h2C);
    le_pulse(); chk("R6 capture on pulse", att, 6'h33);
    par = 6'h01; tick(5); chk("R6 ignore after pulse", att, 6'h33);

    // Serial mode
    cur_req = "R7"; do_reset(1'b1, 1'b0, 6'h2A, 2'b00);
    cur_req = "R3"; shift_word(6'b101101); chk("R3 shift while closed", att, 6'h2A);
    cur_req = "R4"; le_pulse(); chk("R4 latch shifted word", att, 6'b101101);
    cur_req = "R2"; shift_word(6'b100000); le_pulse(); chk("R2 first bit is MSB", att, 6'b100000);
    shift_word(6'b000001); le_pulse(); chk("R2 last bit is LSB", att, 6'b000001);
    cur_req = "R4"; shift_word(6'b000000); le_pulse();
    le = 1'b1; tick(3); chk("R4 transparent zero", att, 6'h00);
    // Shift edge and latch closing in the same sample: bit must stay out
    sdat = 1'b1; tick(3);
    sck = 1'b1; le = 1'b0; tick(4);
    sck = 1'b0; tick(3); chk("R4 same-cycle close excludes shift", att, 6'h00);
    le_pulse(); chk("R4 excluded bit was shifted", att, 6'b000001);
    // Shift seen one sample before closing: bit must get in
    le = 1'b1; tick(3);
    sck = 1'b1; tick(1);
    le = 1'b0; tick(4);
    sck = 1'b0; tick(3); chk("R4 shift before close captured", att, 6'b000011);
    le = 1'b1; shift_bit(1'b0); chk("R4 transparent follows shift", att, 6'b000110);

    // Mode select: serial clocks are ignored in parallel mode
    cur_req = "R1"; mode = 1'b0; par = 6'h0C; tick(4); chk("R1 parallel selected", att, 6'h0C);
    shift_word(6'b111111); chk("R1 serial ignored in parallel", att, 6'h0C);
    mode = 1'b1; tick(4); chk("R1 serial selected", att, 6'b111111);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule